// File: doc/BRIEF.md
# Compare, Complement and Decrement Slice with Condition Codes

This block is the arithmetic slice of an 8-bit accumulator machine that covers three families of operation: comparing a register against memory, forming the one's complement of a byte, and decrementing a byte. It is a combinational path from the operation select and operands to a result, next flag values and per-flag update enables. A small condition-code register captures the enabled flags on each clock.

The surrounding sequencer fetches the memory operands, presents them with the accumulator, the index byte and the 16-bit index pair, and picks one operation. Compares only touch the flags and hand back no result. Complement and decrement hand back a byte and raise a write-enable, so that the sequencer can store it into the accumulator, the index byte or memory. Each family leaves a different set of flags alone, and the enables tell the condition-code register which bits to take.

Top module: `ccalu_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `ccr_o` becomes 0 on that edge, whatever the other inputs are.
- R2: The flag vector layout is V=bit 4, H=bit 3, N=bit 2, Z=bit 1, C=bit 0. A bit of `flag_nxt_o` whose enable in `flag_upd_o` is 0 reads 0.
- R3: Operation code 0 compares the accumulator with `mem_hi_i`, and code 1 compares the index byte with it. The register minus the byte sets V on signed overflow, N from bit 7 of the difference, Z on a zero difference and C on an unsigned borrow. The enables are V, N, Z and C.
- R4: Code 2 compares `pair_i` with the word {`mem_hi_i`,`mem_lo_i`}. The high byte comes from the first address. The same flag rules apply over 16 bits, with N taken from bit 15 and Z needing all 16 bits clear.
- R5: A compare gives `result_o` = 0 and `wr_en_o` = 0.
- R6: Codes 3, 4 and 5 complement the accumulator, the index byte and `mem_hi_i` in that order. `result_o` = 0xFF minus the operand, zero-extended, with `wr_en_o` = 1. V is forced to 0 and C to 1, N and Z follow the result, and the enables are V, N, Z and C.
- R7: Codes 6, 7 and 8 decrement the accumulator, the index byte and `mem_hi_i` in that order. `result_o` = operand minus 1 modulo 256, with `wr_en_o` = 1. V is set only for operand 0x80, N and Z follow the result, and the enables are V, N and Z, leaving C out.
- R8: No operation ever enables H, so bit 3 of `flag_upd_o` is always 0.
- R9: On each rising edge out of reset, every `ccr_o` bit with its enable high takes the `flag_nxt_o` bit, and every other bit keeps its value.
- R10: With `op_valid_i` low, or with an operation code from 9 to 15, all enables are 0, `wr_en_o` is 0, `result_o` is 0 and `ccr_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 4 | Operation code (0 to 8 used) |
| acc_i | input | 8 | Accumulator value |
| idx_i | input | 8 | Index byte value |
| pair_i | input | 16 | 16-bit index pair value |
| mem_hi_i | input | 8 | Memory byte at M (the only byte for 8-bit work) |
| mem_lo_i | input | 8 | Memory byte at M+1 (word compare only) |
| result_o | output | 16 | Result of complement or decrement, zero-extended |
| wr_en_o | output | 1 | Result is meant to be written back |
| flag_nxt_o | output | 5 | Next flag values {V,H,N,Z,C} |
| flag_upd_o | output | 5 | Per-flag update enables {V,H,N,Z,C} |
| ccr_o | output | 5 | Registered condition codes {V,H,N,Z,C} |

## Verification
The result, write-enable, next flags and enables are combinational, so they are valid in the same cycle the operation is presented. The bench drives each vector just after a falling edge and compares these outputs two nanoseconds later, before any clock edge. The condition-code register is one cycle behind: it is checked at the next falling edge, after the single rising edge that loads it, against a bench model that merges the expected flags under the expected enables. The sweeps walk every accumulator, index and memory byte value against a set of corner subtrahends, and step through the word compare with forced-equal and borrow cases.

// File: rtl/ccalu_pkg.sv
// Package: shared widths, flag bit positions and operation codes for the
// compare/complement/decrement slice. Assumes an 8-bit data path.
package ccalu_pkg;
    localparam int FLAG_W = 5;
    localparam int FV = 4;
    localparam int FH = 3;
    localparam int FN = 2;
    localparam int FZ = 1;
    localparam int FC = 0;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_CMP_ACC = 4'd0,
        OP_CMP_IDX = 4'd1,
        OP_CMP_PAIR = 4'd2,
        OP_COM_ACC = 4'd3,
        OP_COM_IDX = 4'd4,
        OP_COM_MEM = 4'd5,
        OP_DEC_ACC = 4'd6,
        OP_DEC_IDX = 4'd7,
        OP_DEC_MEM = 4'd8
    } op_e;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_CMP8,
        CL_CMP16,
        CL_COM,
        CL_DEC
    } opclass_e;
endpackage

// File: rtl/ccalu_opsel.sv
// Operand selector: decodes the operation code into a class and routes the
// accumulator, index byte or memory byte to the compare minuend and to the
// unary (complement/decrement) operand. Assumes codes above 8 are unused.
module ccalu_opsel
    import ccalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              op_valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] idx_i,
    input  logic [DATA_W-1:0] mem_hi_i,
    output opclass_e          cls_o,
    output logic [DATA_W-1:0] minuend_o,
    output logic [DATA_W-1:0] unary_o
);
    // Class decode, gated by the valid strobe.
    always_comb begin
        cls_o = CL_NONE;
        if (op_valid_i) begin
            case (op_i)
                OP_CMP_ACC, OP_CMP_IDX:             cls_o = CL_CMP8;
                OP_CMP_PAIR:                        cls_o = CL_CMP16;
                OP_COM_ACC, OP_COM_IDX, OP_COM_MEM: cls_o = CL_COM;
                OP_DEC_ACC, OP_DEC_IDX, OP_DEC_MEM: cls_o = CL_DEC;
                default:                            cls_o = CL_NONE;
            endcase
        end
    end

    // Register picked as the compare minuend.
    always_comb begin
        minuend_o = (op_i == OP_CMP_IDX) ? idx_i : acc_i;
    end

    // Operand for complement or decrement.
    always_comb begin
        case (op_i)
            OP_COM_ACC, OP_DEC_ACC: unary_o = acc_i;
            OP_COM_IDX, OP_DEC_IDX: unary_o = idx_i;
            default:                unary_o = mem_hi_i;
        endcase
    end
endmodule

// File: rtl/ccalu_subflags.sv
// Subtractor with flags: forms a - b over W bits and reports signed
// overflow, sign, zero and unsigned borrow. Purely combinational.
module ccalu_subflags #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] diff_o,
    output logic         v_o,
    output logic         n_o,
    output logic         z_o,
    output logic         c_o
);
    localparam int MSB = W - 1;
    logic [W:0] wide;

    // Widened subtract; the extra bit is the borrow out.
    always_comb begin
        wide   = {1'b0, a_i} - {1'b0, b_i};
        diff_o = wide[MSB:0];
        c_o    = wide[W];
        n_o    = wide[MSB];
        z_o    = (wide[MSB:0] == '0);
        v_o    = (a_i[MSB] ^ b_i[MSB]) & (wide[MSB] ^ a_i[MSB]);
    end
endmodule

// File: rtl/ccalu_flagsel.sv
// Flag and result selector: given the operation class and the outputs of
// the subtractors, produces the result word, write-enable, next flags and
// per-flag enables. Flags not enabled are driven to zero.
module ccalu_flagsel
    import ccalu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WORD_W = 16
) (
    input  opclass_e          cls_i,
    input  logic [DATA_W-1:0] unary_i,
    input  logic [DATA_W-1:0] dec_diff_i,
    input  logic              dec_v_i,
    input  logic              c8_v_i,
    input  logic              c8_n_i,
    input  logic              c8_z_i,
    input  logic              c8_c_i,
    input  logic              c16_v_i,
    input  logic              c16_n_i,
    input  logic              c16_z_i,
    input  logic              c16_c_i,
    output logic [WORD_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [FLAG_W-1:0] nxt_o,
    output logic [FLAG_W-1:0] upd_o
);
    localparam int MSB = DATA_W - 1;
    logic [DATA_W-1:0] com_val;

    // One's complement of the unary operand.
    always_comb begin
        com_val = ~unary_i;
    end

    // Per-class result, flags and enables.
    always_comb begin
        result_o = '0;
        wr_en_o  = 1'b0;
        nxt_o    = '0;
        upd_o    = '0;
        case (cls_i)
            CL_CMP8: begin
                upd_o     = FLAG_W'(5'b10111);
                nxt_o[FV] = c8_v_i;
                nxt_o[FN] = c8_n_i;
                nxt_o[FZ] = c8_z_i;
                nxt_o[FC] = c8_c_i;
            end
            CL_CMP16: begin
                upd_o     = FLAG_W'(5'b10111);
                nxt_o[FV] = c16_v_i;
                nxt_o[FN] = c16_n_i;
                nxt_o[FZ] = c16_z_i;
                nxt_o[FC] = c16_c_i;
            end
            CL_COM: begin
                result_o  = WORD_W'(com_val);
                wr_en_o   = 1'b1;
                upd_o     = FLAG_W'(5'b10111);
                nxt_o[FV] = 1'b0;
                nxt_o[FN] = com_val[MSB];
                nxt_o[FZ] = (com_val == '0);
                nxt_o[FC] = 1'b1;
            end
            CL_DEC: begin
                result_o  = WORD_W'(dec_diff_i);
                wr_en_o   = 1'b1;
                upd_o     = FLAG_W'(5'b10110);
                nxt_o[FV] = dec_v_i;
                nxt_o[FN] = dec_diff_i[MSB];
                nxt_o[FZ] = (dec_diff_i == '0);
            end
            default: begin
                result_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/ccalu_ccr.sv
// Condition-code register: on each clock loads the enabled flag bits from
// the next-value vector and holds the rest. Synchronous active-low reset.
module ccalu_ccr
    import ccalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] nxt_i,
    input  logic [FLAG_W-1:0] upd_i,
    output logic [FLAG_W-1:0] ccr_o
);
    // Masked flag load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr_o <= '0;
        end else begin
            ccr_o <= (ccr_o & ~upd_i) | (nxt_i & upd_i);
        end
    end

    // R1
    ccr_reset_chk: assert property (@(posedge clk) !rst_n |=> ccr_o == '0);

    // R9
    ccr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ccr_o ^ $past(ccr_o)) & ~$past(upd_i)) == '0);
endmodule

// File: rtl/ccalu_top.sv
// Top of the compare/complement/decrement slice. Combinational result and
// flag path from operation and operands, plus a registered condition-code
// vector. Assumes operands are stable for the cycle they are presented.
module ccalu_top
    import ccalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid_i,
    input  logic [3:0]          op_i,
    input  logic [DATA_W-1:0]   acc_i,
    input  logic [DATA_W-1:0]   idx_i,
    input  logic [2*DATA_W-1:0] pair_i,
    input  logic [DATA_W-1:0]   mem_hi_i,
    input  logic [DATA_W-1:0]   mem_lo_i,
    output logic [2*DATA_W-1:0] result_o,
    output logic                wr_en_o,
    output logic [4:0]          flag_nxt_o,
    output logic [4:0]          flag_upd_o,
    output logic [4:0]          ccr_o
);
    localparam int WORD_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
    localparam logic [DATA_W-1:0] SIGN_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

    opclass_e          cls;
    logic [DATA_W-1:0] minuend;
    logic [DATA_W-1:0] unary;
    logic [DATA_W-1:0] c8_diff;
    logic [WORD_W-1:0] c16_diff;
    logic [DATA_W-1:0] dec_diff;
    logic c8_v, c8_n, c8_z, c8_c;
    logic c16_v, c16_n, c16_z, c16_c;
    logic dec_v, dec_n, dec_z, dec_c;

    ccalu_opsel #(.DATA_W(DATA_W)) u_opsel (
        .op_valid_i(op_valid_i), .op_i(op_i), .acc_i(acc_i), .idx_i(idx_i),
        .mem_hi_i(mem_hi_i), .cls_o(cls), .minuend_o(minuend), .unary_o(unary)
    );

    ccalu_subflags #(.W(DATA_W)) u_cmp8 (
        .a_i(minuend), .b_i(mem_hi_i), .diff_o(c8_diff),
        .v_o(c8_v), .n_o(c8_n), .z_o(c8_z), .c_o(c8_c)
    );

    ccalu_subflags #(.W(WORD_W)) u_cmp16 (
        .a_i(pair_i), .b_i({mem_hi_i, mem_lo_i}), .diff_o(c16_diff),
        .v_o(c16_v), .n_o(c16_n), .z_o(c16_z), .c_o(c16_c)
    );

    ccalu_subflags #(.W(DATA_W)) u_dec (
        .a_i(unary), .b_i(ONE), .diff_o(dec_diff),
        .v_o(dec_v), .n_o(dec_n), .z_o(dec_z), .c_o(dec_c)
    );

    ccalu_flagsel #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_flagsel (
        .cls_i(cls), .unary_i(unary), .dec_diff_i(dec_diff), .dec_v_i(dec_v),
        .c8_v_i(c8_v), .c8_n_i(c8_n), .c8_z_i(c8_z), .c8_c_i(c8_c),
        .c16_v_i(c16_v), .c16_n_i(c16_n), .c16_z_i(c16_z), .c16_c_i(c16_c),
        .result_o(result_o), .wr_en_o(wr_en_o), .nxt_o(flag_nxt_o), .upd_o(flag_upd_o)
    );

    ccalu_ccr u_ccr (
        .clk(clk), .rst_n(rst_n), .nxt_i(flag_nxt_o), .upd_i(flag_upd_o), .ccr_o(ccr_o)
    );

    // R5
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i <= 4'd2) |-> (!wr_en_o && result_o == '0));

    // R4
    word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == 4'd2) |-> (flag_nxt_o[FZ] == (pair_i == {mem_hi_i, mem_lo_i})));

    // R6
    com_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i >= 4'd3 && op_i <= 4'd5)
        |-> (!flag_nxt_o[FV] && flag_nxt_o[FC] && (result_o[DATA_W-1:0] ^ unary) == '1));

    // R7
    dec_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i >= 4'd6 && op_i <= 4'd8)
        |-> (flag_nxt_o[FV] == (unary == SIGN_ONLY) && !flag_upd_o[FC]));

    // R8
    h_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) !flag_upd_o[FH]);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid_i || op_i > 4'd8) |-> (flag_upd_o == '0 && !wr_en_o));
endmodule

// File: tb/ccalu_top_test.sv
module ccalu_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [7:0]  acc_i = '0;
    logic [7:0]  idx_i = '0;
    logic [15:0] pair_i = '0;
    logic [7:0]  mem_hi_i = '0;
    logic [7:0]  mem_lo_i = '0;
    logic [15:0] result_o;
    logic        wr_en_o;
    logic [4:0]  flag_nxt_o;
    logic [4:0]  flag_upd_o;
    logic [4:0]  ccr_o;

    int checks = 0;
    int errors = 0;
    logic [4:0] model_ccr = '0;

    ccalu_top uut (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
        .acc_i(acc_i), .idx_i(idx_i), .pair_i(pair_i), .mem_hi_i(mem_hi_i),
        .mem_lo_i(mem_lo_i), .result_o(result_o), .wr_en_o(wr_en_o),
        .flag_nxt_o(flag_nxt_o), .flag_upd_o(flag_upd_o), .ccr_o(ccr_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected {result, wr_en, nxt, upd} for an 8-bit subtract compare.
    function automatic logic [26:0] exp_cmp8(input int a, input int b);
        int d, sa, sb, s;
        logic v, n, z, c;
        d = (a - b) & 255;
        sa = (a >= 128) ? a - 256 : a;
        sb = (b >= 128) ? b - 256 : b;
        s = sa - sb;
        v = (s < -128) || (s > 127);
        n = (d >= 128);
        z = (d == 0);
        c = (a < b);
        return {16'h0, 1'b0, v, 1'b0, n, z, c, 5'b10111};
    endfunction

    function automatic logic [26:0] exp_cmp16(input int a, input int b);
        int d, sa, sb, s;
        logic v, n, z, c;
        d = (a - b) & 65535;
        sa = (a >= 32768) ? a - 65536 : a;
        sb = (b >= 32768) ? b - 65536 : b;
        s = sa - sb;
        v = (s < -32768) || (s > 32767);
        n = (d >= 32768);
        z = (d == 0);
        c = (a < b);
        return {16'h0, 1'b0, v, 1'b0, n, z, c, 5'b10111};
    endfunction

    function automatic logic [26:0] exp_com(input int a);
        int r;
        r = 255 - a;
        return {16'(r), 1'b1, 1'b0, 1'b0, r >= 128, r == 0, 1'b1, 5'b10111};
    endfunction

    function automatic logic [26:0] exp_dec(input int a);
        int r;
        r = (a + 255) & 255;
        return {16'(r), 1'b1, a == 128, 1'b0, r >= 128, r == 0, 1'b0, 5'b10110};
    endfunction

    // Corner-heavy subtrahend list.
    function automatic int pick_b(input int k);
        case (k)
            16: return 8'h80;
            17: return 8'h7F;
            18: return 8'h01;
            19: return 8'hFE;
            default: return k * 17;
        endcase
    endfunction

    // Drive one vector after a falling edge, check the combinational outputs,
    // and check the register loaded by the previous vector first.
    task automatic apply(input string tag, input logic vld, input logic [3:0] op,
                         input logic [7:0] a, input logic [7:0] x, input logic [15:0] p,
                         input logic [7:0] mh, input logic [7:0] ml, input logic [26:0] exp);
        @(negedge clk);
        check("R9 ccr", {27'h0, ccr_o}, {27'h0, model_ccr});
        op_valid_i = vld; op_i = op; acc_i = a; idx_i = x;
        pair_i = p; mem_hi_i = mh; mem_lo_i = ml;
        #2;
        check(tag, {5'h0, result_o, wr_en_o, flag_nxt_o, flag_upd_o}, {5'h0, exp});
        model_ccr = (model_ccr & ~exp[4:0]) | (exp[9:5] & exp[4:0]);
    endtask

    initial begin
        // R1: reset dominates an operation that enables every flag it can.
        op_valid_i = 1'b1; op_i = 4'd3; acc_i = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset ccr", {27'h0, ccr_o}, 32'h0);
        rst_n = 1'b1;
        op_valid_i = 1'b0;
        model_ccr = '0;

        // R3 R2 R8: accumulator and index compares over every minuend byte.
        for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 20; k++) begin
                int b = pick_b(k);
                apply("R3 cmp acc", 1'b1, 4'd0, 8'(a), 8'(255 - a), 16'h1234, 8'(b), 8'(a),
                      exp_cmp8(a, b));
                apply("R3 cmp idx", 1'b1, 4'd1, 8'(b ^ 8'h5A), 8'(a), 16'h4321, 8'(b), 8'(k),
                      exp_cmp8(a, b));
            end
        end

        // R4 R5: word compare, with forced equality and borrow cases.
        for (int i = 0; i < 4096; i++) begin
            int p, m;
            p = (i * 16 + (i >> 4) * 4099) & 65535;
            m = (i % 7 == 0) ? p : ((i * 40503) & 65535);
            if (i == 1) begin p = 16'h8000; m = 16'h0001; end
            if (i == 2) begin p = 16'h7FFF; m = 16'hFFFF; end
            if (i == 3) begin p = 16'h0000; m = 16'h0001; end
            apply("R4 cmp pair", 1'b1, 4'd2, 8'(i), 8'(i >> 3), 16'(p), 8'(m >> 8), 8'(m),
                  exp_cmp16(p, m));
        end

        // R6 R7: complement and decrement of each source, every byte value.
        for (int a = 0; a < 256; a++) begin
            apply("R6 com acc", 1'b1, 4'd3, 8'(a), 8'(a + 1), 16'h0, 8'(a + 2), 8'h0, exp_com(a));
            apply("R6 com idx", 1'b1, 4'd4, 8'(a + 3), 8'(a), 16'h0, 8'(a + 4), 8'h0, exp_com(a));
            apply("R6 com mem", 1'b1, 4'd5, 8'(a + 5), 8'(a + 6), 16'h0, 8'(a), 8'h0, exp_com(a));
            apply("R7 dec acc", 1'b1, 4'd6, 8'(a), 8'(a + 7), 16'h0, 8'(a + 8), 8'h0, exp_dec(a));
            apply("R7 dec idx", 1'b1, 4'd7, 8'(a + 9), 8'(a), 16'h0, 8'(a + 10), 8'h0, exp_dec(a));
            apply("R7 dec mem", 1'b1, 4'd8, 8'(a + 11), 8'(a + 12), 16'h0, 8'(a), 8'h0, exp_dec(a));
        end

        // R7 R9: carry set by a borrowing compare survives a decrement.
        apply("R3 borrow", 1'b1, 4'd0, 8'h00, 8'h00, 16'h0, 8'h01, 8'h0, exp_cmp8(0, 1));
        apply("R7 dec keep C", 1'b1, 4'd6, 8'h80, 8'h00, 16'h0, 8'h00, 8'h0, exp_dec(128));
        @(negedge clk);
        check("R7 C held", {31'h0, ccr_o[0]}, 32'h1);

        // R10: idle strobe and unused codes leave everything quiet.
        for (int op = 0; op < 16; op++) begin
            apply("R10 not valid", 1'b0, 4'(op), 8'h00, 8'h00, 16'h0, 8'h01, 8'h0, 27'h0);
        end
        for (int op = 9; op < 16; op++) begin
            apply("R10 unused code", 1'b1, 4'(op), 8'h00, 8'hFF, 16'h0, 8'h01, 8'h0, 27'h0);
        end
        @(negedge clk);
        check("R10 ccr unchanged", {27'h0, ccr_o}, {27'h0, model_ccr});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule